// File: doc/BRIEF.md
# Segmented Scan Chain Controller

This block steers a scan chain that has been cut into several segments so that only one segment shifts at any time during scan load and unload. In shift, only the chosen segment's clock enable is raised and that segment alone takes tester data on its scan input. Every idle segment is fed a constant zero. A gating enable stops scan flop outputs from reaching downstream logic while shifting is under way. In capture, or in functional operation, every segment is clocked together and the output gating is released.

The active segment comes from one of two places. In manual mode it is a binary index on an input. In automatic mode an internal sequencer walks the segments in ascending order, moving on after a programmable number of shift cycles, and raises a done flag once the last segment has had its turn. The serial test output is the tail bit of the active segment. All outputs are registered and appear one clock after the inputs that cause them.

Top module: `scan_seg_ctrl`

## Requirements
- R1: After synchronous reset, seg_clk_en, seg_si, q_gate_en, tdo and seq_done are all 0.
- R2: In manual mode, with scan_en=1, func_mode=0 and seg_sel < NSEG, the next cycle's seg_clk_en has only bit seg_sel set.
- R3: While shifting, the seg_si bit of the active segment equals the previous cycle's tdi, and every other seg_si bit is 0.
- R4: q_gate_en is 1 in a cycle exactly when the previous cycle had scan_en=1 and func_mode=0.
- R5: When the previous cycle had scan_en=0 or func_mode=1, seg_clk_en is all ones and seg_si and tdo are 0.
- R6: In manual shift with seg_sel >= NSEG, the next cycle's seg_clk_en and seg_si are all zero and tdo is 0.
- R7: While shifting with a valid active segment, tdo equals the previous cycle's seg_tail bit of that segment.
- R8: In automatic mode, one cycle with auto_start=1 begins a pass that enables segments 0, 1, ..., NSEG-1 in turn, each for shift_len shift cycles (a shift_len of 0 counts as 1), with the first enable two cycles after the start.
- R9: During an automatic pass, cycles with scan_en=0 or func_mode=1 give chip-wide capture enables and do not count toward the current segment's shift_len.
- R10: seq_done rises in the same cycle as the last segment's final shift enable, stays 1 until the next auto_start or reset, and is 0 while a pass runs.
- R11: In automatic mode with no pass running, shift cycles enable no segment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | 1 = shift, 0 = capture |
| func_mode | input | 1 | Functional operation; overrides scan_en |
| auto_mode | input | 1 | 1 = sequencer picks the segment, 0 = seg_sel picks it |
| auto_start | input | 1 | Starts an automatic pass (used only in automatic mode) |
| seg_sel | input | SEL_W | Binary index of the segment to shift in manual mode |
| shift_len | input | CNT_W | Shift cycles per segment in automatic mode |
| tdi | input | 1 | Serial test data from the tester |
| seg_tail | input | NSEG | Last flop output of each segment |
| seg_clk_en | output | NSEG | Per-segment clock enable |
| seg_si | output | NSEG | Scan input driven into each segment |
| q_gate_en | output | 1 | Blocks scan flop outputs from logic while shifting |
| tdo | output | 1 | Serial test data from the active segment's tail |
| seq_done | output | 1 | Automatic pass has finished |

## Verification
The manual path is driven with a vector table that sweeps each in-range index with both tdi values and different tail patterns. Each row shows whether the enable, the data and the output mux all track the same index and whether idle segments stay at zero. Rows with capture and functional settings separate the chip-wide capture path from the shift path. Indices just past the last segment and at the top of the select range show that invalid selects close every segment but leave the output gating on. Automatic passes, one uninterrupted and one with a capture cycle inside a segment's window, check the ordering, the per-segment count, the timing of the done flag and that the count holds across a pause.

// File: rtl/scan_seg_pkg.sv
package scan_seg_pkg;
  // How the output stage drives the segments in a given cycle
  typedef enum logic [1:0] {
    RM_CAPTURE = 2'd0, // all segments clocked, no gating
    RM_SHIFT1  = 2'd1, // exactly one segment shifts
    RM_SHIFT0  = 2'd2  // shift cycle, but no segment is selected
  } route_mode_e;
endpackage

// File: rtl/scan_seg_seq.sv
module scan_seg_seq #(
  parameter int NSEG  = 4,
  parameter int SEL_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_mode,
  input  logic             auto_start,
  input  logic             shifting,
  input  logic [CNT_W-1:0] shift_len,
  output logic             run,
  output logic [SEL_W-1:0] idx,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic             last_cyc;
  logic             last_seg;

  // shift_len of zero behaves as one
  assign last_cyc = ({1'b0, cnt} + 1'b1) >= {1'b0, shift_len};
  assign last_seg = (32'(idx) == NSEG - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      idx  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (auto_mode && auto_start) begin
      run  <= 1'b1;
      idx  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (auto_mode && run && shifting) begin
      if (last_cyc) begin
        cnt <= '0;
        if (last_seg) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10: a finished pass is never still running
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !run);
  // R8: the walked index stays inside the segment range
  a_r8_idx_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (32'(idx) < NSEG));
  // R9: a pause in shifting holds the active segment
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !shifting && !auto_start) |=> $stable(idx));
endmodule

// File: rtl/scan_seg_route.sv
module scan_seg_route
  import scan_seg_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  route_mode_e      mode,
  input  logic [SEL_W-1:0] act,
  input  logic             tdi,
  input  logic [NSEG-1:0]  seg_tail,
  output logic [NSEG-1:0]  seg_clk_en,
  output logic [NSEG-1:0]  seg_si,
  output logic             q_gate_en,
  output logic             tdo
);
  logic [NSEG-1:0] sel_mask;
  logic            tail_bit;

  // decode of the active index, one comparator per segment
  for (genvar g = 0; g < NSEG; g++) begin : g_dec
    assign sel_mask[g] = (32'(act) == g);
  end

  always_comb begin
    tail_bit = 1'b0;
    for (int i = 0; i < NSEG; i++)
      if (sel_mask[i]) tail_bit = seg_tail[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_clk_en <= '0;
      seg_si     <= '0;
      q_gate_en  <= 1'b0;
      tdo        <= 1'b0;
    end else begin
      case (mode)
        RM_SHIFT1: begin
          seg_clk_en <= sel_mask;
          seg_si     <= tdi ? sel_mask : '0;
          q_gate_en  <= 1'b1;
          tdo        <= tail_bit;
        end
        RM_SHIFT0: begin
          seg_clk_en <= '0;
          seg_si     <= '0;
          q_gate_en  <= 1'b1;
          tdo        <= 1'b0;
        end
        default: begin
          seg_clk_en <= '1;
          seg_si     <= '0;
          q_gate_en  <= 1'b0;
          tdo        <= 1'b0;
        end
      endcase
    end
  end

  // R2: during shift at most one segment is clocked
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    q_gate_en |-> $onehot0(seg_clk_en));
  // R3: a segment that is not clocked only ever sees zero
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
    q_gate_en |-> ((seg_si & ~seg_clk_en) == '0));
  // R5: capture cycles clock every segment with gating released
  a_r5_capture_all: assert property (@(posedge clk) disable iff (rst)
    (mode == RM_CAPTURE) |=> (seg_clk_en == '1 && !q_gate_en && seg_si == '0));
endmodule

// File: rtl/scan_seg_ctrl.sv
module scan_seg_ctrl
  import scan_seg_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int SEL_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_en,
  input  logic             func_mode,
  input  logic             auto_mode,
  input  logic             auto_start,
  input  logic [SEL_W-1:0] seg_sel,
  input  logic [CNT_W-1:0] shift_len,
  input  logic             tdi,
  input  logic [NSEG-1:0]  seg_tail,
  output logic [NSEG-1:0]  seg_clk_en,
  output logic [NSEG-1:0]  seg_si,
  output logic             q_gate_en,
  output logic             tdo,
  output logic             seq_done
);
  localparam int MAX_SEL = (1 << SEL_W);

  logic             shifting;
  logic             seq_run;
  logic [SEL_W-1:0] seq_idx;
  logic [SEL_W-1:0] act;
  logic             act_ok;
  route_mode_e      mode;

  initial begin
    if (MAX_SEL < NSEG) $error("SEL_W too narrow for NSEG");
  end

  assign shifting = scan_en && !func_mode;

  scan_seg_seq #(.NSEG(NSEG), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .auto_mode  (auto_mode),
    .auto_start (auto_start),
    .shifting   (shifting),
    .shift_len  (shift_len),
    .run        (seq_run),
    .idx        (seq_idx),
    .done       (seq_done)
  );

  always_comb begin
    if (auto_mode) begin
      act    = seq_idx;
      act_ok = seq_run;
    end else begin
      act    = seg_sel;
      act_ok = (32'(seg_sel) < NSEG);
    end
    if (!shifting)   mode = RM_CAPTURE;
    else if (act_ok) mode = RM_SHIFT1;
    else             mode = RM_SHIFT0;
  end

  scan_seg_route #(.NSEG(NSEG), .SEL_W(SEL_W)) u_route (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .act        (act),
    .tdi        (tdi),
    .seg_tail   (seg_tail),
    .seg_clk_en (seg_clk_en),
    .seg_si     (seg_si),
    .q_gate_en  (q_gate_en),
    .tdo        (tdo)
  );

  // R6: an index past the last segment shuts every segment
  a_r6_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (shifting && !auto_mode && 32'(seg_sel) >= NSEG) |=> (seg_clk_en == '0 && seg_si == '0));
  // R4: output gating follows the shift condition one cycle later
  a_r4_gate: assert property (@(posedge clk) disable iff (rst)
    shifting |=> q_gate_en);
endmodule

// File: tb/scan_seg_ctrl_bench.sv
module scan_seg_ctrl_bench;
  localparam int NSEG  = 4;
  localparam int SEL_W = 3;
  localparam int CNT_W = 8;
  localparam int NVEC  = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             scan_en = 1'b0, func_mode = 1'b0, auto_mode = 1'b0, auto_start = 1'b0;
  logic [SEL_W-1:0] seg_sel = '0;
  logic [CNT_W-1:0] shift_len = '0;
  logic             tdi = 1'b0;
  logic [NSEG-1:0]  seg_tail = '0;
  logic [NSEG-1:0]  seg_clk_en, seg_si;
  logic             q_gate_en, tdo, seq_done;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  scan_seg_ctrl #(.NSEG(NSEG), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_scan_seg_ctrl (
    .clk(clk), .rst(rst), .scan_en(scan_en), .func_mode(func_mode),
    .auto_mode(auto_mode), .auto_start(auto_start), .seg_sel(seg_sel),
    .shift_len(shift_len), .tdi(tdi), .seg_tail(seg_tail),
    .seg_clk_en(seg_clk_en), .seg_si(seg_si), .q_gate_en(q_gate_en),
    .tdo(tdo), .seq_done(seq_done)
  );

  // {scan_en, func_mode, sel[2:0], tdi, tail[3:0], exp_en[3:0], exp_si[3:0], exp_q, exp_tdo, req[3:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 3'd0, 1'b1, 4'b0000, 4'b0001, 4'b0001, 1'b1, 1'b0, 4'd2}, // R2 R3
    {1'b1, 1'b0, 3'd2, 1'b1, 4'b0100, 4'b0100, 4'b0100, 1'b1, 1'b1, 4'd7}, // R7
    {1'b1, 1'b0, 3'd3, 1'b0, 4'b0111, 4'b1000, 4'b0000, 1'b1, 1'b0, 4'd3}, // R3
    {1'b1, 1'b0, 3'd3, 1'b1, 4'b1000, 4'b1000, 4'b1000, 1'b1, 1'b1, 4'd7}, // R7
    {1'b1, 1'b0, 3'd1, 1'b0, 4'b1101, 4'b0010, 4'b0000, 1'b1, 1'b0, 4'd2}, // R2
    {1'b0, 1'b0, 3'd1, 1'b1, 4'b1111, 4'b1111, 4'b0000, 1'b0, 1'b0, 4'd5}, // R5 R4
    {1'b1, 1'b1, 3'd2, 1'b1, 4'b1111, 4'b1111, 4'b0000, 1'b0, 1'b0, 4'd5}, // R5 R4
    {1'b0, 1'b1, 3'd0, 1'b1, 4'b1111, 4'b1111, 4'b0000, 1'b0, 1'b0, 4'd5}, // R5
    {1'b1, 1'b0, 3'd4, 1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b0, 4'd6}, // R6
    {1'b1, 1'b0, 3'd7, 1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b0, 4'd6}  // R6
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    step(); step();
    // R1: reset state
    chk("R1", "clk_en", 32'(seg_clk_en), 0);
    chk("R1", "si", 32'(seg_si), 0);
    chk("R1", "q_gate", 32'(q_gate_en), 0);
    chk("R1", "tdo/done", {tdo, seq_done}, 0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      string rq;
      @(negedge clk);
      {scan_en, func_mode, seg_sel, tdi, seg_tail} = VEC[i][23:14];
      step();
      rq = $sformatf("R%0d", VEC[i][3:0]);
      chk(rq, "clk_en", 32'(seg_clk_en), 32'(VEC[i][13:10]));
      chk(rq, "si", 32'(seg_si), 32'(VEC[i][9:6]));
      chk("R4", "q_gate", 32'(q_gate_en), 32'(VEC[i][5]));
      chk(rq, "tdo", 32'(tdo), 32'(VEC[i][4]));
    end

    // R11: automatic mode, no pass running
    @(negedge clk);
    auto_mode = 1'b1; scan_en = 1'b1; func_mode = 1'b0; shift_len = 8'd3; tdi = 1'b1;
    seg_tail = 4'b1010;
    step();
    chk("R11", "clk_en idle", 32'(seg_clk_en), 0);

    // R8: full pass, three shifts per segment
    @(negedge clk) auto_start = 1'b1;
    step();
    chk("R8", "clk_en start cycle", 32'(seg_clk_en), 0);
    @(negedge clk) auto_start = 1'b0;
    for (int s = 0; s < NSEG; s++) begin
      for (int k = 0; k < 3; k++) begin
        step();
        chk("R8", $sformatf("clk_en seg%0d", s), 32'(seg_clk_en), 32'(1 << s));
        chk("R7", "tdo auto", 32'(tdo), 32'(seg_tail[s]));
        chk("R10", "done timing", 32'(seq_done), 32'((s == NSEG - 1) && (k == 2)));
      end
    end
    step();
    chk("R11", "clk_en after pass", 32'(seg_clk_en), 0);
    chk("R10", "done held", 32'(seq_done), 1);

    // R9: pause inside segment 0, shift_len 2
    @(negedge clk) begin auto_start = 1'b1; shift_len = 8'd2; end
    step();
    chk("R10", "done cleared", 32'(seq_done), 0);
    @(negedge clk) auto_start = 1'b0;
    step();
    chk("R9", "seg0 first", 32'(seg_clk_en), 32'b0001);
    @(negedge clk) scan_en = 1'b0;
    step();
    chk("R9", "capture in pass", 32'(seg_clk_en), 32'b1111);
    @(negedge clk) scan_en = 1'b1;
    step();
    chk("R9", "seg0 second", 32'(seg_clk_en), 32'b0001);
    step();
    chk("R9", "seg1 after pause", 32'(seg_clk_en), 32'b0010);

    // R8: shift_len of zero counts as one
    @(negedge clk) begin auto_start = 1'b1; shift_len = 8'd0; end
    @(negedge clk) auto_start = 1'b0;
    for (int s = 0; s < NSEG; s++) begin
      step();
      chk("R8", $sformatf("len0 seg%0d", s), 32'(seg_clk_en), 32'(1 << s));
    end
    chk("R10", "len0 done", 32'(seq_done), 1);

    // R1: reset mid-pass
    @(negedge clk) auto_start = 1'b1;
    @(negedge clk) begin auto_start = 1'b0; rst = 1'b1; end
    step();
    chk("R1", "clk_en after reset", 32'(seg_clk_en), 0);
    chk("R1", "done after reset", 32'(seq_done), 0);
    summary();
  end
endmodule